// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries a 32-bit processor core from the moment an exception is accepted to the moment the handler can start. The core presents one request that carries a class, a vector number and, for interrupts, the accepted priority level. It also presents its current status word, program counter, stack pointer and table base. The sequencer then runs single-word transfers on a plain request/acknowledge memory bus.

For address errors, instruction exceptions and interrupts, the sequencer saves the status word and the program counter below the stack pointer. It then reads the handler address from the vector slot. It returns a new program counter, a new stack pointer and a new status word, and marks them with a one-cycle done pulse. Only interrupts rewrite the four-bit mask field of the status word. A reset request saves nothing. It reads the start program counter and the start stack pointer from two adjacent slots of a table at address zero.

A request that arrives while a sequence runs is dropped, unless it is a reset. A reset request abandons the running sequence and starts the reset fetch at once.

Top module: `exc_entry_seq`

## Requirements
- R1: For classes 1 (address error), 2 (instruction) and 3 (interrupt), the first bus transfer is a write of the captured status word to SP-4. The second is a write of the captured program counter to SP-8. No other writes occur.
- R2: For classes 1 to 3, the third and last transfer is a read at base + 4*vector. The data read becomes the new program counter.
- R3: For class 3, the new status word carries the request level in bits 7:4. Every other bit is taken from the captured status word.
- R4: For classes 1 and 2, the new status word equals the captured status word, and the mask field in bits 7:4 is untouched.
- R5: For class 0 (reset), no write occurs. Two reads are made, at 4*vector and then at 4*vector+4, with the table base taken as zero. The first read gives the new program counter and the second gives the new stack pointer. The status word passes through unchanged.
- R6: For classes 1 to 3, the new stack pointer is the captured SP minus 8.
- R7: Status word, program counter, stack pointer, base, vector and level are captured in the cycle a request is accepted. Later changes on those inputs do not affect the running sequence.
- R8: Each transfer holds its address, direction and write data until acknowledge. Done is high for exactly one cycle, in the cycle after the final acknowledge, and the bus request is low in that cycle.
- R9: A request of class 1, 2 or 3 that arrives while a sequence is running is ignored. The running sequence finishes with its own results and its own transfers.
- R10: A class 0 request that arrives during a sequence abandons it without completing the pending transfer. Reset fetching then starts from the new vector.
- R11: After reset, bus request and done are low, and the new program counter, stack pointer and status word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_class | input | 2 | 0 reset, 1 address error, 2 instruction, 3 interrupt |
| req_vector | input | 8 | Vector number |
| req_level | input | 4 | Interrupt priority level |
| cur_pc | input | 32 | Program counter value to be saved |
| cur_sr | input | 32 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| tbl_base | input | 32 | Vector table base for non-reset classes |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| new_pc | output | 32 | Handler / start program counter |
| new_sp | output | 32 | Resulting stack pointer |
| new_sr | output | 32 | Resulting status word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit vectors, 4-byte slots and the mask field at bits 7:4. This lets it reach every vector from 0 up to 255, so slot offsets run up to 0x3FC and the reset pair's second slot reaches 0x400. The power-of-two slot size selects the shift form of the address generator. With a full 32-bit stack pointer and random inputs, the SP-4 and SP-8 subtractions wrap below zero in some runs. Random acknowledge latency of zero to two wait cycles exercises the hold-until-acknowledge rule. An acknowledge that is held back keeps a transfer open long enough to inject an abandoning reset.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      EXC_RESET    = 2'd0,
      EXC_ADDR_ERR = 2'd1,
      EXC_INSTR    = 2'd2,
      EXC_IRQ      = 2'd3
   } exc_class_e;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_PUSH_SR   = 3'd1,
      ST_PUSH_PC   = 3'd2,
      ST_FETCH_VEC = 3'd3,
      ST_FETCH_RPC = 3'd4,
      ST_FETCH_RSP = 3'd5
   } seq_state_e;

   function automatic logic is_final_state(seq_state_e s);
      return (s == ST_FETCH_VEC) || (s == ST_FETCH_RSP);
   endfunction

endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
   import exc_seq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int VEC_W      = 8,
   parameter int SLOT_BYTES = 4
) (
   input  logic [DATA_W-1:0] base,
   input  logic [VEC_W-1:0]  vec,
   output logic [DATA_W-1:0] slot_addr,
   output logic [DATA_W-1:0] next_addr
);
   localparam int  SLOT_SHIFT = $clog2(SLOT_BYTES);
   localparam bit  SLOT_POW2  = ((1 << SLOT_SHIFT) == SLOT_BYTES);
   localparam logic [DATA_W-1:0] SLOT_STEP = DATA_W'(SLOT_BYTES);

   logic [DATA_W-1:0] vec_ext;
   logic [DATA_W-1:0] offset;

   assign vec_ext = {{(DATA_W-VEC_W){1'b0}}, vec};

   generate
      if (SLOT_POW2) begin : g_shift
         assign offset = vec_ext << SLOT_SHIFT;
      end else begin : g_mult
         assign offset = vec_ext * SLOT_STEP;
      end
   endgenerate

   assign slot_addr = base + offset;
   assign next_addr = slot_addr + SLOT_STEP;

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
   import exc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_is_reset,
   input  logic       bus_ack,
   output seq_state_e state,
   output logic       start,
   output logic       step,
   output logic       done
);
   seq_state_e state_nx;
   logic       finish;

   assign start  = req_valid && ((state == ST_IDLE) || req_is_reset);
   assign step   = bus_ack && (state != ST_IDLE) && !start;
   assign finish = step && is_final_state(state);

   always_comb begin
      state_nx = state;
      if (start) begin
         state_nx = req_is_reset ? ST_FETCH_RPC : ST_PUSH_SR;
      end else if (step) begin
         unique case (state)
            ST_PUSH_SR:   state_nx = ST_PUSH_PC;
            ST_PUSH_PC:   state_nx = ST_FETCH_VEC;
            ST_FETCH_VEC: state_nx = ST_IDLE;
            ST_FETCH_RPC: state_nx = ST_FETCH_RSP;
            ST_FETCH_RSP: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= finish;
      end
   end

   // R8: an open transfer keeps its state until acknowledge
   assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && !bus_ack && !(req_valid && req_is_reset)) |=> state == $past(state));

   // R8: done is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: a reset request always lands on the start-PC fetch
   assert_reset_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_reset) |=> state == ST_FETCH_RPC);

   // R9: a non-reset request while busy does not restart the stacking
   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_reset && state != ST_IDLE && !bus_ack) |=> state == $past(state));

endmodule

// File: rtl/exc_seq_ctx.sv
module exc_seq_ctx
   import exc_seq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int VEC_W    = 8,
   parameter int MASK_W   = 4,
   parameter int MASK_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic              done,
   input  seq_state_e        state,
   input  exc_class_e        req_class,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic [MASK_W-1:0] req_level,
   input  logic [DATA_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] cur_sr,
   input  logic [DATA_W-1:0] cur_sp,
   input  logic [DATA_W-1:0] tbl_base,
   input  logic [DATA_W-1:0] bus_rdata,
   output exc_class_e        ctx_cls,
   output logic [VEC_W-1:0]  ctx_vec,
   output logic [DATA_W-1:0] ctx_pc,
   output logic [DATA_W-1:0] ctx_sr,
   output logic [DATA_W-1:0] ctx_sp,
   output logic [DATA_W-1:0] ctx_base,
   output logic [DATA_W-1:0] new_pc,
   output logic [DATA_W-1:0] new_sp,
   output logic [DATA_W-1:0] new_sr
);
   localparam int WORD_BYTES  = DATA_W / 8;
   localparam logic [DATA_W-1:0] FRAME_BYTES = DATA_W'(2 * WORD_BYTES);
   localparam logic [DATA_W-1:0] MASK_ONES   = DATA_W'((1 << MASK_W) - 1);
   localparam logic [DATA_W-1:0] MASK_FIELD  = MASK_ONES << MASK_LSB;

   logic [MASK_W-1:0] ctx_lvl;
   logic [DATA_W-1:0] pc_stage;
   logic [DATA_W-1:0] sr_masked;
   logic [DATA_W-1:0] sr_result;

   assign sr_masked = (ctx_sr & ~MASK_FIELD) | (DATA_W'(ctx_lvl) << MASK_LSB);
   assign sr_result = (ctx_cls == EXC_IRQ) ? sr_masked : ctx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_cls  <= EXC_RESET;
         ctx_vec  <= '0;
         ctx_lvl  <= '0;
         ctx_pc   <= '0;
         ctx_sr   <= '0;
         ctx_sp   <= '0;
         ctx_base <= '0;
      end else if (start) begin
         ctx_cls  <= req_class;
         ctx_vec  <= req_vector;
         ctx_lvl  <= req_level;
         ctx_pc   <= cur_pc;
         ctx_sr   <= cur_sr;
         ctx_sp   <= cur_sp;
         ctx_base <= (req_class == EXC_RESET) ? '0 : tbl_base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_stage <= '0;
         new_pc   <= '0;
         new_sp   <= '0;
         new_sr   <= '0;
      end else if (step) begin
         unique case (state)
            ST_FETCH_RPC: pc_stage <= bus_rdata;
            ST_FETCH_RSP: begin
               new_pc <= pc_stage;
               new_sp <= bus_rdata;
               new_sr <= ctx_sr;
            end
            ST_FETCH_VEC: begin
               new_pc <= bus_rdata;
               new_sp <= ctx_sp - FRAME_BYTES;
               new_sr <= sr_result;
            end
            default: ;
         endcase
      end
   end

   // R3: interrupt result carries the level in the mask field
   assert_irq_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctx_cls == EXC_IRQ) |-> new_sr[MASK_LSB +: MASK_W] == ctx_lvl);

   // R4: other exceptions keep the whole status word
   assert_mask_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (ctx_cls == EXC_ADDR_ERR || ctx_cls == EXC_INSTR)) |-> new_sr == ctx_sr);

   // R6: stacking leaves SP two words lower
   assert_sp_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctx_cls != EXC_RESET) |-> new_sp == ctx_sp - FRAME_BYTES);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int VEC_W      = 8,
   parameter int MASK_W     = 4,
   parameter int MASK_LSB   = 4,
   parameter int SLOT_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_class,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic [MASK_W-1:0] req_level,
   input  logic [DATA_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] cur_sr,
   input  logic [DATA_W-1:0] cur_sp,
   input  logic [DATA_W-1:0] tbl_base,
   output logic              bus_req,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] new_pc,
   output logic [DATA_W-1:0] new_sp,
   output logic [DATA_W-1:0] new_sr,
   output logic              done
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(WORD_BYTES);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("exc_entry_seq: DATA_W must be a byte multiple of at least 16");
      end
      if (VEC_W < 1 || VEC_W >= DATA_W) begin : g_bad_vec
         $error("exc_entry_seq: VEC_W out of range");
      end
      if (MASK_W < 1 || MASK_LSB + MASK_W > DATA_W) begin : g_bad_mask
         $error("exc_entry_seq: mask field does not fit the status word");
      end
      if (SLOT_BYTES < 1) begin : g_bad_slot
         $error("exc_entry_seq: SLOT_BYTES must be positive");
      end
   endgenerate

   exc_class_e        cls_in;
   seq_state_e        state;
   logic              start;
   logic              step;
   logic              req_is_reset;
   exc_class_e        ctx_cls;
   logic [VEC_W-1:0]  ctx_vec;
   logic [DATA_W-1:0] ctx_pc;
   logic [DATA_W-1:0] ctx_sr;
   logic [DATA_W-1:0] ctx_sp;
   logic [DATA_W-1:0] ctx_base;
   logic [DATA_W-1:0] slot_addr;
   logic [DATA_W-1:0] next_addr;

   assign cls_in       = exc_class_e'(req_class);
   assign req_is_reset = (cls_in == EXC_RESET);

   exc_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_is_reset (req_is_reset),
      .bus_ack      (bus_ack),
      .state        (state),
      .start        (start),
      .step         (step),
      .done         (done)
   );

   exc_seq_ctx #(
      .DATA_W   (DATA_W),
      .VEC_W    (VEC_W),
      .MASK_W   (MASK_W),
      .MASK_LSB (MASK_LSB)
   ) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .step       (step),
      .done       (done),
      .state      (state),
      .req_class  (cls_in),
      .req_vector (req_vector),
      .req_level  (req_level),
      .cur_pc     (cur_pc),
      .cur_sr     (cur_sr),
      .cur_sp     (cur_sp),
      .tbl_base   (tbl_base),
      .bus_rdata  (bus_rdata),
      .ctx_cls    (ctx_cls),
      .ctx_vec    (ctx_vec),
      .ctx_pc     (ctx_pc),
      .ctx_sr     (ctx_sr),
      .ctx_sp     (ctx_sp),
      .ctx_base   (ctx_base),
      .new_pc     (new_pc),
      .new_sp     (new_sp),
      .new_sr     (new_sr)
   );

   exc_vec_addr #(
      .DATA_W     (DATA_W),
      .VEC_W      (VEC_W),
      .SLOT_BYTES (SLOT_BYTES)
   ) u_addr (
      .base      (ctx_base),
      .vec       (ctx_vec),
      .slot_addr (slot_addr),
      .next_addr (next_addr)
   );

   always_comb begin
      bus_req   = 1'b1;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (state)
         ST_PUSH_SR: begin
            bus_we    = 1'b1;
            bus_addr  = ctx_sp - WORD_STEP;
            bus_wdata = ctx_sr;
         end
         ST_PUSH_PC: begin
            bus_we    = 1'b1;
            bus_addr  = ctx_sp - (WORD_STEP << 1);
            bus_wdata = ctx_pc;
         end
         ST_FETCH_VEC, ST_FETCH_RPC: bus_addr = slot_addr;
         ST_FETCH_RSP:               bus_addr = next_addr;
         default:                    bus_req  = 1'b0;
      endcase
   end

   // R5: reset sequences never write
   assert_reset_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && ctx_cls == EXC_RESET) |-> !bus_we);

   // R8: address and data hold while a transfer waits
   assert_bus_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !(req_valid && req_is_reset))
         |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

   // R8: no transfer is requested in the done cycle
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_class = 2'd0;
   logic [7:0]  req_vector = 8'd0;
   logic [3:0]  req_level = 4'd0;
   logic [31:0] cur_pc = '0, cur_sr = '0, cur_sp = '0, tbl_base = '0;
   logic        bus_req, bus_we, bus_ack = 1'b0, done;
   logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
   logic [31:0] new_pc, new_sp, new_sr;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   bit hold_ack = 0;
   int log_n = 0;
   logic [31:0] log_addr [8];
   logic [31:0] log_data [8];
   logic        log_we   [8];

   always #4 clk = ~clk;

   exc_entry_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .req_vector(req_vector), .req_level(req_level), .cur_pc(cur_pc),
      .cur_sr(cur_sr), .cur_sp(cur_sp), .tbl_base(tbl_base),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .new_pc(new_pc), .new_sp(new_sp), .new_sr(new_sr), .done(done)
   );

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] exp_sr(logic [1:0] c, logic [31:0] sr, logic [3:0] l);
      if (c == 2'd3) return (sr & ~32'h0000_00F0) | {24'd0, l, 4'd0};
      return sr;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder: random wait of 0..2 cycles, one-cycle acknowledge
   initial begin
      int wait_n;
      wait_n = 0;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
            wait_n  = int'($urandom % 3);
         end else if (bus_req && !hold_ack) begin
            if (wait_n == 0) begin
               bus_ack   = 1'b1;
               bus_rdata = mem_word(bus_addr);
               if (log_n < 8) begin
                  log_addr[log_n] = bus_addr;
                  log_data[log_n] = bus_wdata;
                  log_we[log_n]   = bus_we;
               end
               log_n++;
            end else begin
               wait_n--;
            end
         end
      end
   end

   task automatic wait_done(input bit inject, output bit got);
      bit pend;
      pend = inject;
      got  = 0;
      for (int i = 0; i < 400 && !got; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (done) got = 1;
         else if (pend && log_n >= 1) begin
            req_valid  = 1'b1;
            req_class  = 2'd3;
            req_vector = 8'd50;
            req_level  = 4'd9;
            pend = 0;
         end
      end
   endtask

   task automatic check_result(input logic [1:0] c, input logic [7:0] v, input logic [3:0] l,
                               input logic [31:0] pc, sr, sp, base, input bit got);
      logic [31:0] a;
      chk(got, "R8 done seen", 32'(got), 32'd1);
      chk(!bus_req, "R8 bus idle at done", 32'(bus_req), 32'd0);
      if (c == 2'd0) begin
         a = {22'd0, v, 2'b00};
         chk(log_n == 2, "R5 reset transfer count", 32'(log_n), 32'd2);
         chk(!log_we[0] && !log_we[1], "R5 reset no writes", {30'd0, log_we[0], log_we[1]}, 32'd0);
         chk(log_addr[0] == a, "R5 start PC slot", log_addr[0], a);
         chk(log_addr[1] == a + 4, "R5 start SP slot", log_addr[1], a + 4);
         chk(new_pc == mem_word(a), "R5 new PC", new_pc, mem_word(a));
         chk(new_sp == mem_word(a + 4), "R5 new SP", new_sp, mem_word(a + 4));
         chk(new_sr == sr, "R5 SR passes", new_sr, sr);
      end else begin
         a = base + {22'd0, v, 2'b00};
         chk(log_n == 3, "R1 transfer count", 32'(log_n), 32'd3);
         chk(log_we[0] && log_addr[0] == sp - 4, "R1 SR push addr", log_addr[0], sp - 4);
         chk(log_data[0] == sr, "R1 SR push data", log_data[0], sr);
         chk(log_we[1] && log_addr[1] == sp - 8, "R1 PC push addr", log_addr[1], sp - 8);
         chk(log_data[1] == pc, "R7 stacked PC", log_data[1], pc);
         chk(!log_we[2] && log_addr[2] == a, "R2 vector read addr", log_addr[2], a);
         chk(new_pc == mem_word(a), "R2 handler PC", new_pc, mem_word(a));
         chk(new_sp == sp - 8, "R6 new SP", new_sp, sp - 8);
         if (c == 2'd3) chk(new_sr == exp_sr(c, sr, l), "R3 mask from level", new_sr, exp_sr(c, sr, l));
         else           chk(new_sr == sr, "R4 mask kept", new_sr, sr);
      end
      @(negedge clk);
      chk(!done, "R8 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic run_exc(input logic [1:0] c, input logic [7:0] v, input logic [3:0] l,
                          input logic [31:0] pc, sr, sp, base, input bit inject);
      bit got;
      log_n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_class = c; req_vector = v; req_level = l;
      cur_pc = pc; cur_sr = sr; cur_sp = sp; tbl_base = base;
      @(negedge clk);
      req_valid = 1'b0;
      // R7: disturb the inputs once the request is taken
      cur_pc = $urandom; cur_sr = $urandom; cur_sp = $urandom; tbl_base = $urandom;
      req_vector = $urandom; req_level = $urandom;
      wait_done(inject, got);
      check_result(c, v, l, pc, sr, sp, base, got);
   endtask

   initial begin
      bit got;
      logic [31:0] s;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!bus_req && !done, "R11 idle after reset", {30'd0, bus_req, done}, 32'd0);
      chk(new_pc == 0 && new_sp == 0 && new_sr == 0, "R11 outputs zero", new_pc | new_sp | new_sr, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_exc(2'd0, 8'd0, 4'd0, 32'h1111_0000, 32'h0000_00F0, 32'h0, 32'h0, 0);
      run_exc(2'd0, 8'd2, 4'd0, 32'h0, 32'h0000_0AB3, 32'h0, 32'h0, 0);
      run_exc(2'd3, 8'd11, 4'd15, 32'h0000_4000, 32'h0000_0003, 32'hFFFF_F000, 32'h8000_0000, 0);
      run_exc(2'd1, 8'd9, 4'd7, 32'h0000_1234, 32'h0000_00A1, 32'h0000_0100, 32'h0000_0400, 0);
      run_exc(2'd2, 8'd4, 4'd2, 32'hDEAD_BEE0, 32'hFFFF_FFFF, 32'h0000_0004, 32'h0, 0);
      run_exc(2'd3, 8'd255, 4'd0, 32'h0000_0010, 32'hFFFF_FFFF, 32'h2000_0000, 32'h0000_1000, 0);
      run_exc(2'd0, 8'd255, 4'd0, 32'h0, 32'h5, 32'h0, 32'h0, 0);
      // R9: request injected while busy is dropped
      run_exc(2'd1, 8'd6, 4'd1, 32'hCAFE_0000, 32'h0000_0050, 32'h0000_8000, 32'h0000_0200, 1);
      run_exc(2'd0, 8'd2, 4'd0, 32'h0, 32'h77, 32'h0, 32'h0, 1);

      // R10: reset abandons an open transfer
      hold_ack = 1; log_n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_class = 2'd3; req_vector = 8'd12; req_level = 4'd3;
      cur_pc = 32'h100; cur_sr = 32'h0; cur_sp = 32'h4000; tbl_base = 32'h9000;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(bus_req && bus_we && bus_addr == 32'h3FFC, "R8 held write waits", bus_addr, 32'h3FFC);
      s = 32'h0000_0C3C;
      req_valid = 1'b1; req_class = 2'd0; req_vector = 8'd2; cur_sr = s;
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_req && !bus_we && bus_addr == 32'h8, "R10 restart at reset slot", bus_addr, 32'h8);
      hold_ack = 0;
      wait_done(0, got);
      check_result(2'd0, 8'd2, 4'd0, 32'h0, s, 32'h0, 32'h0, got);

      for (int k = 0; k < 40; k++) begin
         run_exc(2'($urandom % 4), 8'($urandom), 4'($urandom), $urandom, $urandom,
                 $urandom, $urandom, k % 5 == 0);
      end

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule